// File: doc/BRIEF.md
# BPF Branch Condition and Target Unit

This unit resolves one jump-class instruction of a 64-bit packet-filter virtual machine per cycle. It takes the 4-bit operation code, a class bit that selects full-width or low-half comparison, a source-select bit, the destination register value, the source register value, the 32-bit immediate, the 16-bit signed offset and the byte address of the current instruction slot. From these it decides whether the branch is taken and forms the address of the next instruction.

Instructions occupy 8-byte slots. A taken branch lands `(offset + 1)` slots past the current one. The helper call and the program end are reported as one-cycle pulses, and the surrounding core acts on them. Malformed encodings are flagged instead of executed. All results are registered and appear one clock after the instruction is presented with `i_valid` high.

Top module: `bpf_branch_unit`

## Requirements
- R1: Codes 2 (greater), 3 (greater-or-equal), 10 (less) and 11 (less-or-equal) compare the destination against the second operand as unsigned numbers; `o_taken` is 1 exactly when the relation holds.
- R2: Codes 6, 7, 12 and 13 apply the relations greater, greater-or-equal, less and less-or-equal to the two operands read as two's-complement signed numbers.
- R3: Code 1 is taken on equality, code 5 on inequality, and code 4 when the bitwise AND of the two operands is nonzero.
- R4: With `i_narrow`=1 only bits 31:0 of both operands take part in a comparison: zero-extended for the unsigned, equality and bit-test codes, sign-extended for the signed codes. With `i_narrow`=0 all 64 bits take part.
- R5: A taken branch sets `o_next_pc` to `i_pc + (sext(i_offset) + 1) * 8`. Code 0 is always taken, in either class.
- R6: A conditional branch that is not taken, or an illegal instruction, sets `o_next_pc` to `i_pc + 8` with `o_taken`=0.
- R7: Code 8 with `i_narrow`=0 raises `o_call` and `o_taken`, and sets `o_next_pc` to `i_pc + (sext(i_imm) + 1) * 8`.
- R8: Code 9 with `i_narrow`=0 raises `o_exit` with `o_taken`=0, and `o_next_pc` equals `i_pc`.
- R9: Codes 14 and 15 in either class, and codes 8 and 9 with `i_narrow`=1, raise `o_illegal` with `o_taken`, `o_call` and `o_exit` all 0.
- R10: With `i_src_reg`=1 the second operand is `i_src_val`. With `i_src_reg`=0 it is `i_imm` sign-extended to 64 bits, and `i_src_val` has no effect.
- R11: The outputs appear on the clock edge after the one that samples `i_valid`=1. In a cycle after `i_valid`=0, `o_valid`, `o_taken`, `o_call`, `o_exit` and `o_illegal` are all 0, so each flag is a one-cycle pulse.
- R12: While `rst_n`=0 at a clock edge, every output becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_valid | input | 1 | An instruction is presented this cycle |
| i_code | input | 4 | Jump operation code |
| i_narrow | input | 1 | 1 = compare the low 32 bits only |
| i_src_reg | input | 1 | 1 = the second operand is the source register; 0 = the immediate |
| i_dst_val | input | 64 | Destination register value |
| i_src_val | input | 64 | Source register value |
| i_imm | input | 32 | Signed immediate (operand or call displacement) |
| i_offset | input | 16 | Signed branch offset in slots |
| i_pc | input | 64 | Byte address of the current instruction |
| o_valid | output | 1 | The result outputs are meaningful |
| o_next_pc | output | 64 | Address of the next instruction |
| o_taken | output | 1 | Control transfers to the branch target |
| o_call | output | 1 | Helper-call pulse |
| o_exit | output | 1 | Program-end pulse |
| o_illegal | output | 1 | Malformed jump encoding |

## Verification
The assertions check these rules on every cycle: the one-cycle latency and the pulse behaviour, the fact that the call, exit and illegal flags never overlap, the unconditional jump target, the sequential and held addresses, and the flagging of the unused codes. The bench scenarios are the only way to show whether each comparison code picks the right signedness and operand width. They use operand pairs chosen so that the signed and unsigned readings disagree, or so that the upper 32 bits alone decide the result. The bench also shows that the immediate and register operands are selected correctly, and that offsets and call displacements at their extremes give the right addresses.

// File: rtl/bpf_br_pkg.sv
// Package: shared encodings for the BPF branch unit.
// Assumes the 4-bit jump operation code layout used by both jump classes.
package bpf_br_pkg;

    typedef enum logic [3:0] {
        J_JA   = 4'h0,
        J_JEQ  = 4'h1,
        J_JGT  = 4'h2,
        J_JGE  = 4'h3,
        J_JSET = 4'h4,
        J_JNE  = 4'h5,
        J_JSGT = 4'h6,
        J_JSGE = 4'h7,
        J_CALL = 4'h8,
        J_EXIT = 4'h9,
        J_JLT  = 4'hA,
        J_JLE  = 4'hB,
        J_JSLT = 4'hC,
        J_JSLE = 4'hD,
        J_RSVE = 4'hE,
        J_RSVF = 4'hF
    } jcode_e;

    typedef struct packed {
        logic taken;
        logic call;
        logic fin;
        logic illegal;
        logic imm_disp;
    } br_flags_t;

endpackage

// File: rtl/bpf_br_operand.sv
// Operand shaper: selects the second operand (register or sign-extended
// immediate) and produces unsigned- and signed-compare views of both
// operands, narrowed to NARROW_W bits when the narrow class is selected.
// Assumes XLEN > IMM_W and XLEN > NARROW_W.
module bpf_br_operand #(
    parameter int XLEN     = 64,
    parameter int NARROW_W = 32,
    parameter int IMM_W    = 32
) (
    input  logic            narrow,
    input  logic            use_reg,
    input  logic [XLEN-1:0] dst_val,
    input  logic [XLEN-1:0] src_val,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0] ua,
    output logic [XLEN-1:0] ub,
    output logic [XLEN-1:0] sa,
    output logic [XLEN-1:0] sb
);
    localparam int EXT_W = XLEN - NARROW_W;

    logic [XLEN-1:0] rhs;
    logic [XLEN-1:0] raw   [2];
    logic [XLEN-1:0] uview [2];
    logic [XLEN-1:0] sview [2];

    // Pick the second operand: register or sign-extended immediate.
    always_comb rhs = use_reg ? src_val : {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

    assign raw[0] = dst_val;
    assign raw[1] = rhs;

    genvar k;
    generate
        for (k = 0; k < 2; k++) begin : g_view
            // Form the zero- and sign-extended views of one operand.
            always_comb begin
                if (narrow) begin
                    uview[k] = {{EXT_W{1'b0}}, raw[k][NARROW_W-1:0]};
                    sview[k] = {{EXT_W{raw[k][NARROW_W-1]}}, raw[k][NARROW_W-1:0]};
                end else begin
                    uview[k] = raw[k];
                    sview[k] = raw[k];
                end
            end
        end
    endgenerate

    assign ua = uview[0];
    assign ub = uview[1];
    assign sa = sview[0];
    assign sb = sview[1];

endmodule

// File: rtl/bpf_br_cond.sv
// Condition evaluator: decides whether the relation named by the jump code
// holds between the shaped operands. Non-conditional codes give 0.
module bpf_br_cond
    import bpf_br_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  jcode_e          code,
    input  logic [XLEN-1:0] ua,
    input  logic [XLEN-1:0] ub,
    input  logic [XLEN-1:0] sa,
    input  logic [XLEN-1:0] sb,
    output logic            hit
);
    logic signed [XLEN-1:0] ssa;
    logic signed [XLEN-1:0] ssb;

    assign ssa = sa;
    assign ssb = sb;

    // Evaluate the selected relation.
    always_comb begin
        unique case (code)
            J_JEQ:   hit = (ua == ub);
            J_JNE:   hit = (ua != ub);
            J_JSET:  hit = |(ua & ub);
            J_JGT:   hit = (ua >  ub);
            J_JGE:   hit = (ua >= ub);
            J_JLT:   hit = (ua <  ub);
            J_JLE:   hit = (ua <= ub);
            J_JSGT:  hit = (ssa >  ssb);
            J_JSGE:  hit = (ssa >= ssb);
            J_JSLT:  hit = (ssa <  ssb);
            J_JSLE:  hit = (ssa <= ssb);
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bpf_br_decode.sv
// Control decoder: turns the jump code, class and condition result into
// taken / call / exit / illegal flags and the displacement source.
module bpf_br_decode
    import bpf_br_pkg::*;
(
    input  jcode_e    code,
    input  logic      narrow,
    input  logic      hit,
    output br_flags_t flags
);
    // Classify the instruction.
    always_comb begin
        flags = '0;
        unique case (code)
            J_JA: flags.taken = 1'b1;
            J_CALL: begin
                if (narrow) begin
                    flags.illegal = 1'b1;
                end else begin
                    flags.call     = 1'b1;
                    flags.taken    = 1'b1;
                    flags.imm_disp = 1'b1;
                end
            end
            J_EXIT: begin
                if (narrow) flags.illegal = 1'b1;
                else        flags.fin     = 1'b1;
            end
            J_JEQ, J_JNE, J_JSET, J_JGT, J_JGE, J_JLT, J_JLE,
            J_JSGT, J_JSGE, J_JSLT, J_JSLE: flags.taken = hit;
            default: flags.illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/bpf_br_target.sv
// Target generator: forms the sequential, jump and held next addresses and
// selects one. Displacements count slots of SLOT_BYTES bytes, plus one.
// Assumes SLOT_BYTES is a power of two and PC_W exceeds both field widths.
module bpf_br_target #(
    parameter int PC_W       = 64,
    parameter int OFF_W      = 16,
    parameter int IMM_W      = 32,
    parameter int SLOT_BYTES = 8
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic [IMM_W-1:0] imm,
    input  logic             imm_disp,
    input  logic             taken,
    input  logic             hold,
    output logic [PC_W-1:0]  next_pc
);
    localparam int SLOT_SHIFT = $clog2(SLOT_BYTES);

    logic [PC_W-1:0] disp;
    logic [PC_W-1:0] jump_pc;
    logic [PC_W-1:0] seq_pc;

    // Sign-extend the chosen displacement field.
    always_comb disp = imm_disp ? {{(PC_W-IMM_W){imm[IMM_W-1]}}, imm}
                                : {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};

    // Jump and fall-through addresses.
    always_comb begin
        jump_pc = pc + ((disp + PC_W'(1)) << SLOT_SHIFT);
        seq_pc  = pc + PC_W'(SLOT_BYTES);
    end

    // Choose the next address.
    always_comb begin
        if (hold)       next_pc = pc;
        else if (taken) next_pc = jump_pc;
        else            next_pc = seq_pc;
    end

endmodule

// File: rtl/bpf_branch_unit.sv
// Top: BPF branch condition and target unit. Resolves one jump-class
// instruction per cycle and registers the result (latency one clock).
// Assumes a synchronous active-low reset; flags are single-cycle pulses.
module bpf_branch_unit
    import bpf_br_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int NARROW_W   = 32,
    parameter int IMM_W      = 32,
    parameter int OFF_W      = 16,
    parameter int PC_W       = 64,
    parameter int SLOT_BYTES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_valid,
    input  logic [3:0]       i_code,
    input  logic             i_narrow,
    input  logic             i_src_reg,
    input  logic [XLEN-1:0]  i_dst_val,
    input  logic [XLEN-1:0]  i_src_val,
    input  logic [IMM_W-1:0] i_imm,
    input  logic [OFF_W-1:0] i_offset,
    input  logic [PC_W-1:0]  i_pc,
    output logic             o_valid,
    output logic [PC_W-1:0]  o_next_pc,
    output logic             o_taken,
    output logic             o_call,
    output logic             o_exit,
    output logic             o_illegal
);
    localparam int SLOT_SHIFT = $clog2(SLOT_BYTES);

    jcode_e          code;
    logic [XLEN-1:0] ua, ub, sa, sb;
    logic            hit;
    br_flags_t       flags;
    logic [PC_W-1:0] nxt;

    assign code = jcode_e'(i_code);

    bpf_br_operand #(.XLEN(XLEN), .NARROW_W(NARROW_W), .IMM_W(IMM_W)) u_opnd (
        .narrow  (i_narrow),
        .use_reg (i_src_reg),
        .dst_val (i_dst_val),
        .src_val (i_src_val),
        .imm     (i_imm),
        .ua      (ua),
        .ub      (ub),
        .sa      (sa),
        .sb      (sb)
    );

    bpf_br_cond #(.XLEN(XLEN)) u_cond (
        .code (code),
        .ua   (ua),
        .ub   (ub),
        .sa   (sa),
        .sb   (sb),
        .hit  (hit)
    );

    bpf_br_decode u_dec (
        .code   (code),
        .narrow (i_narrow),
        .hit    (hit),
        .flags  (flags)
    );

    bpf_br_target #(.PC_W(PC_W), .OFF_W(OFF_W), .IMM_W(IMM_W),
                    .SLOT_BYTES(SLOT_BYTES)) u_tgt (
        .pc       (i_pc),
        .offset   (i_offset),
        .imm      (i_imm),
        .imm_disp (flags.imm_disp),
        .taken    (flags.taken),
        .hold     (flags.fin),
        .next_pc  (nxt)
    );

    // Result register; flags cleared in cycles with no instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid   <= 1'b0;
            o_next_pc <= '0;
            o_taken   <= 1'b0;
            o_call    <= 1'b0;
            o_exit    <= 1'b0;
            o_illegal <= 1'b0;
        end else begin
            o_valid   <= i_valid;
            o_taken   <= i_valid & flags.taken;
            o_call    <= i_valid & flags.call;
            o_exit    <= i_valid & flags.fin;
            o_illegal <= i_valid & flags.illegal;
            if (i_valid) o_next_pc <= nxt;
        end
    end

    // R11: results follow a presented instruction by exactly one clock.
    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        i_valid |=> o_valid);

    // R11: no flag without a valid result.
    p_pulse_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (o_taken | o_call | o_exit | o_illegal) |-> o_valid);

    // R9: call, exit and illegal never coincide; illegal is never taken.
    p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({o_call, o_exit, o_illegal}) && !(o_illegal && o_taken));

    // R9: unused codes are flagged.
    p_rsv_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && i_code[3:1] == 3'b111) |=> o_illegal);

    // R5: unconditional jump lands offset+1 slots ahead.
    p_ja_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && i_code == 4'h0) |=>
        (o_taken && o_next_pc - $past(i_pc) ==
            (($past({{(PC_W-OFF_W){i_offset[OFF_W-1]}}, i_offset}) + PC_W'(1)) << SLOT_SHIFT)));

    // R6: a result that neither jumps nor ends advances by one slot.
    p_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_taken && !o_exit) |-> (o_next_pc == $past(i_pc) + PC_W'(SLOT_BYTES)));

    // R8: program end holds the address and is not a taken branch.
    p_exit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        o_exit |-> (!o_taken && o_next_pc == $past(i_pc)));

endmodule

// File: tb/sim_bpf_branch_unit.sv
module sim_bpf_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_valid = 1'b0;
    logic [3:0]  i_code = '0;
    logic        i_narrow = 1'b0;
    logic        i_src_reg = 1'b0;
    logic [63:0] i_dst_val = '0;
    logic [63:0] i_src_val = '0;
    logic [31:0] i_imm = '0;
    logic [15:0] i_offset = '0;
    logic [63:0] i_pc = '0;
    logic        o_valid;
    logic [63:0] o_next_pc;
    logic        o_taken, o_call, o_exit, o_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bpf_branch_unit u0 (
        .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_code(i_code),
        .i_narrow(i_narrow), .i_src_reg(i_src_reg), .i_dst_val(i_dst_val),
        .i_src_val(i_src_val), .i_imm(i_imm), .i_offset(i_offset), .i_pc(i_pc),
        .o_valid(o_valid), .o_next_pc(o_next_pc), .o_taken(o_taken),
        .o_call(o_call), .o_exit(o_exit), .o_illegal(o_illegal)
    );

    // Compare every output against expectations; v,t,c,e,i then PC.
    task automatic expect_out(input string req, input logic v, input logic t,
                              input logic c, input logic e, input logic il,
                              input logic [63:0] pc);
        logic [68:0] act, exp;
        act = {o_valid, o_taken, o_call, o_exit, o_illegal, o_next_pc};
        exp = {v, t, c, e, il, pc};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual v%b t%b c%b e%b i%b pc=%h expected v%b t%b c%b e%b i%b pc=%h",
                     req, o_valid, o_taken, o_call, o_exit, o_illegal, o_next_pc,
                     v, t, c, e, il, pc);
        end
    endtask

    // Present one instruction for one cycle; outputs are ready on return.
    task automatic fire(input logic [3:0] code, input logic nar, input logic rx,
                        input logic [63:0] d, input logic [63:0] s,
                        input logic [31:0] im, input logic [15:0] off,
                        input logic [63:0] pc);
        @(negedge clk);
        i_valid = 1'b1; i_code = code; i_narrow = nar; i_src_reg = rx;
        i_dst_val = d; i_src_val = s; i_imm = im; i_offset = off; i_pc = pc;
        @(negedge clk);
        i_valid = 1'b0;
    endtask

    // Conditional branch helper: taken -> +4 slots (off 3), else +8.
    task automatic cond(input string req, input logic [3:0] code, input logic nar,
                        input logic rx, input logic [63:0] d, input logic [63:0] s,
                        input logic [31:0] im, input logic exp_t);
        fire(code, nar, rx, d, s, im, 16'd3, 64'h1000);
        expect_out(req, 1'b1, exp_t, 1'b0, 1'b0, 1'b0, exp_t ? 64'h1020 : 64'h1008);
    endtask

    task automatic t_reset;
        @(negedge clk);
        i_valid = 1'b1; i_code = 4'h0; i_pc = 64'h55;
        @(negedge clk);
        expect_out("R12 reset", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0);
        i_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_unsigned;
        cond("R1 jgt 5>3",        4'h2, 1'b0, 1'b1, 64'd5, 64'd3, 32'd0, 1'b1);
        cond("R1 jgt 3>5",        4'h2, 1'b0, 1'b1, 64'd3, 64'd5, 32'd0, 1'b0);
        cond("R1 jge equal",      4'h3, 1'b0, 1'b1, 64'd9, 64'd9, 32'd0, 1'b1);
        cond("R1 jlt 1<all-ones", 4'hA, 1'b0, 1'b0, 64'd1, 64'd0, 32'hFFFF_FFFF, 1'b1);
        cond("R1 jle neg-as-big", 4'hB, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0, 1'b0);
    endtask

    task automatic t_signed;
        cond("R2 jsgt -1>1",  4'h6, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0, 1'b0);
        cond("R2 jslt -1<1",  4'hC, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0, 1'b1);
        cond("R2 jsge equal", 4'h7, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 64'd0, 32'hFFFF_FFFE, 1'b1);
        cond("R2 jsle 2<=-3", 4'hD, 1'b0, 1'b1, 64'd2, 64'hFFFF_FFFF_FFFF_FFFD, 32'd0, 1'b0);
    endtask

    task automatic t_equality;
        cond("R3 jeq",          4'h1, 1'b0, 1'b1, 64'h1234, 64'h1234, 32'd0, 1'b1);
        cond("R3 jne same",     4'h5, 1'b0, 1'b1, 64'h1234, 64'h1234, 32'd0, 1'b0);
        cond("R3 jset disjoint",4'h4, 1'b0, 1'b1, 64'h0F, 64'hF0, 32'd0, 1'b0);
        cond("R3 jset overlap", 4'h4, 1'b0, 1'b1, 64'h18, 64'h10, 32'd0, 1'b1);
    endtask

    task automatic t_narrow;
        cond("R4 jeq narrow",     4'h1, 1'b1, 1'b1, 64'h1_0000_0005, 64'd5, 32'd0, 1'b1);
        cond("R4 jeq wide",       4'h1, 1'b0, 1'b1, 64'h1_0000_0005, 64'd5, 32'd0, 1'b0);
        cond("R4 jsgt narrow",    4'h6, 1'b1, 1'b1, 64'h8000_0000, 64'd1, 32'd0, 1'b0);
        cond("R4 jsgt wide",      4'h6, 1'b0, 1'b1, 64'h8000_0000, 64'd1, 32'd0, 1'b1);
        cond("R4 jgt narrow",     4'h2, 1'b1, 1'b1, 64'hFFFF_FFFF_0000_0001, 64'd2, 32'd0, 1'b0);
        cond("R4 jset high only", 4'h4, 1'b1, 1'b1, 64'hFF00_0000_0000, 64'hFF00_0000_0000, 32'd0, 1'b0);
    endtask

    task automatic t_target;
        fire(4'h0, 1'b0, 1'b0, '0, '0, '0, 16'hFFFF, 64'h2000);
        expect_out("R5 ja self", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h2000);
        fire(4'h0, 1'b0, 1'b0, '0, '0, '0, 16'h7FFF, 64'h1000);
        expect_out("R5 ja max fwd", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h41000);
        fire(4'h0, 1'b1, 1'b0, '0, '0, '0, 16'hFFFE, 64'h100);
        expect_out("R5 ja narrow back", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 64'hF8);
        fire(4'h0, 1'b0, 1'b0, '0, '0, '0, 16'h8000, 64'h10_0000);
        expect_out("R5 ja max back", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 64'hC_0008);
    endtask

    task automatic t_seq;
        fire(4'h1, 1'b0, 1'b1, 64'd1, 64'd2, '0, 16'h0100, 64'hFFFF_FFFF_FFFF_FFF8);
        expect_out("R6 fallthrough wraps", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0);
    endtask

    task automatic t_call;
        fire(4'h8, 1'b0, 1'b0, '0, '0, 32'd4, 16'h0, 64'h200);
        expect_out("R7 call fwd", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 64'h228);
        fire(4'h8, 1'b0, 1'b0, '0, '0, 32'hFFFF_FFFD, 16'h7, 64'h200);
        expect_out("R7 call back", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 64'h1F0);
    endtask

    task automatic t_exit;
        fire(4'h9, 1'b0, 1'b0, '0, '0, 32'd5, 16'h5, 64'h3330);
        expect_out("R8 exit", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 64'h3330);
    endtask

    task automatic t_illegal;
        fire(4'hE, 1'b0, 1'b1, 64'd1, 64'd1, '0, 16'h3, 64'h1000);
        expect_out("R9 code E", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 64'h1008);
        fire(4'hF, 1'b1, 1'b1, 64'd1, 64'd1, '0, 16'h3, 64'h1000);
        expect_out("R9 code F", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 64'h1008);
        fire(4'h8, 1'b1, 1'b0, '0, '0, 32'd4, 16'h0, 64'h1000);
        expect_out("R9 narrow call", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 64'h1008);
        fire(4'h9, 1'b1, 1'b0, '0, '0, '0, 16'h0, 64'h1000);
        expect_out("R9 narrow exit", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 64'h1008);
    endtask

    task automatic t_source;
        cond("R10 imm used",       4'h1, 1'b0, 1'b0, 64'd7, 64'd9, 32'd7, 1'b1);
        cond("R10 reg used",       4'h1, 1'b0, 1'b1, 64'd7, 64'd9, 32'd7, 1'b0);
        cond("R10 imm sign-ext",   4'h1, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_idle;
        fire(4'h8, 1'b0, 1'b0, '0, '0, 32'd0, 16'h0, 64'h400);
        expect_out("R11 call pulse", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 64'h408);
        @(negedge clk);
        expect_out("R11 idle after pulse", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h408);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_equality();
        t_narrow();
        t_target();
        t_seq();
        t_call();
        t_exit();
        t_illegal();
        t_source();
        t_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule